// File: doc/BRIEF.md
# Page Permission Checker with Fault Recording

This block sits after a page table walk and decides whether the access that caused the walk may go ahead. It takes the kind of access (load, store, instruction fetch or a combined store-and-fetch), the privilege of the requester, the 3-bit permission code and the modified flag of the final page table entry, and a no-fault control. From these it produces a 2-bit error code and the read, write and execute rights that a TLB fill may install. A store right is never handed out while the entry is still unmodified, so that the first store comes back through the walk and can mark the page dirty.

When a strobed access is refused, the block records the fault in two registers. The fault status register holds the access index, the error code and a fixed marker bit. If an earlier fault was never read, the block sets an overflow mark. The fault address register holds the full virtual address. A read strobe on the register port clears the status register. The rights and error outputs are combinational. The two registers update on the clock edge.

Top module: `pte_access_guard`

## Requirements
- R1: The access index is {store, fetch, supervisor} (bit 2 store, bit 1 fetch, bit 0 supervisor). A recorded fault with no prior pending status sets fault status = (index << 5) | error_code | 2'b10, in an 8-bit register.
- R2: A user access (supervisor = 0) to permission code 6 or 7 returns error code 3 (privilege), for every access kind, unless no-fault mode applies.
- R3: Otherwise the error code is 2 (protection) when the access lacks a right it needs, and 0 when it has them all. A load needs R, a fetch needs X, a store needs W, and store-with-fetch needs both W and X.
- R4: The base rights for a user, by permission code 0..7, are R, RW, RX, RWX, X, R, none, none. A supervisor gets the same for codes 0..4, and RW, RX, RWX for codes 5, 6, 7.
- R5: grant_w is 0 whenever pte_modified is 0, even if the base rights include W.
- R6: When err_code is nonzero, grant_r, grant_w and grant_x are all 0.
- R7: When nofault_en is 1, a user access that would fail reports err_code 0, receives its base rights (W still gated by R5) and records nothing. Supervisor accesses are not affected by nofault_en.
- R8: When a fault is recorded while the status register is nonzero and no read strobe is present, the old contents are replaced by 1 (overflow) before the new fields are ORed in.
- R9: Every recorded fault loads far_q with the full acc_vaddr of that access.
- R10: fsr_rd clears the status register on the next edge. If a fault arrives in the same cycle, it is recorded onto the cleared value, without overflow.
- R11: After reset both registers read zero. A failing access with acc_valid low changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One-cycle strobe qualifying fault recording |
| acc_write | input | 1 | Access is a store |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Requester is supervisor |
| pte_perm | input | 3 | Permission code of the final page table entry |
| pte_modified | input | 1 | Modified flag of the entry |
| nofault_en | input | 1 | No-fault mode for user accesses |
| acc_vaddr | input | VA_W | Virtual address of the access |
| fsr_rd | input | 1 | Read strobe, clears the status register |
| err_code | output | 2 | 0 allowed, 2 protection, 3 privilege |
| grant_r | output | 1 | Read right to install |
| grant_w | output | 1 | Write right to install |
| grant_x | output | 1 | Execute right to install |
| fsr_q | output | 8 | Fault status register |
| far_q | output | VA_W | Fault address register |

## Verification
A wrong cell in the permission decode shows up right away on err_code and the grant outputs in the same cycle, and the combinational sweep over all 64 index/code pairs with both modified values exposes it. A fault in the recording path stays hidden until the cycle after a strobed fault, when fsr_q or far_q holds the wrong value. A broken overflow or clear rule only appears on the second of two back-to-back faults, or on a fault that meets a read strobe, so those sequences are driven on purpose.

// File: rtl/perm_pkg.sv
package perm_pkg;
  localparam int PERM_W = 3;
  localparam int IDX_W  = 3;
  localparam int ERR_W  = 2;
  localparam int FSR_W  = 8;
  localparam int IDX_LSB = 5;

  localparam logic [ERR_W-1:0] ERR_NONE = 2'd0;
  localparam logic [ERR_W-1:0] ERR_PROT = 2'd2;
  localparam logic [ERR_W-1:0] ERR_PRIV = 2'd3;

  localparam logic [FSR_W-1:0] FSR_MARK = 8'h02;
  localparam logic [FSR_W-1:0] FSR_OVF  = 8'h01;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rights_t;
endpackage

// File: rtl/perm_rights.sv
module perm_rights
  import perm_pkg::*;
(
  input  logic [PERM_W-1:0] perm,
  input  logic              super_mode,
  output rights_t           rights
);
  rights_t user_r;
  rights_t upper_r;

  // codes 0..4 are common to both privileges
  always_comb begin
    unique case (perm)
      3'd0:    user_r = '{r: 1'b1, w: 1'b0, x: 1'b0};
      3'd1:    user_r = '{r: 1'b1, w: 1'b1, x: 1'b0};
      3'd2:    user_r = '{r: 1'b1, w: 1'b0, x: 1'b1};
      3'd3:    user_r = '{r: 1'b1, w: 1'b1, x: 1'b1};
      3'd4:    user_r = '{r: 1'b0, w: 1'b0, x: 1'b1};
      3'd5:    user_r = '{r: 1'b1, w: 1'b0, x: 1'b0};
      default: user_r = '{r: 1'b0, w: 1'b0, x: 1'b0};
    endcase
  end

  // supervisor view of codes 5..7
  always_comb begin
    unique case (perm)
      3'd5:    upper_r = '{r: 1'b1, w: 1'b1, x: 1'b0};
      3'd6:    upper_r = '{r: 1'b1, w: 1'b0, x: 1'b1};
      3'd7:    upper_r = '{r: 1'b1, w: 1'b1, x: 1'b1};
      default: upper_r = user_r;
    endcase
  end

  assign rights = super_mode ? upper_r : user_r;
endmodule

// File: rtl/perm_access_check.sv
module perm_access_check
  import perm_pkg::*;
(
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [PERM_W-1:0] perm,
  input  rights_t           base,
  output logic [ERR_W-1:0]  err
);
  logic is_user;
  logic need_r;
  logic need_w;
  logic need_x;
  logic lacking;

  always_comb begin
    is_user = ~acc_idx[0];
    need_w  = acc_idx[2];
    need_x  = acc_idx[1];
    need_r  = ~acc_idx[2] & ~acc_idx[1];
    lacking = (need_r & ~base.r) | (need_w & ~base.w) | (need_x & ~base.x);
    if (is_user && (perm[2:1] == 2'b11)) begin
      err = ERR_PRIV;
    end else if (lacking) begin
      err = ERR_PROT;
    end else begin
      err = ERR_NONE;
    end
  end
endmodule

// File: rtl/perm_fault_log.sv
module perm_fault_log
  import perm_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_en,
  input  logic             rd_clr,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [ERR_W-1:0] err,
  input  logic [VA_W-1:0]  vaddr,
  output logic [FSR_W-1:0] fsr_q,
  output logic [VA_W-1:0]  far_q
);
  logic [FSR_W-1:0] fsr_base;
  logic [FSR_W-1:0] fsr_d;
  logic             fsr_en;
  logic             far_en;

  always_comb begin
    fsr_base = rd_clr ? '0 : fsr_q;
    fsr_d    = fsr_base;
    if (rec_en) begin
      if (fsr_base != '0) begin
        fsr_d = FSR_OVF;
      end
      fsr_d = fsr_d | ({{(FSR_W-IDX_W){1'b0}}, acc_idx} << IDX_LSB)
                    | {{(FSR_W-ERR_W){1'b0}}, err} | FSR_MARK;
    end
    fsr_en = rec_en | rd_clr;
    far_en = rec_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
    end else if (fsr_en) begin
      fsr_q <= fsr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      far_q <= '0;
    end else if (far_en) begin
      far_q <= vaddr;
    end
  end
endmodule

// File: rtl/pte_access_guard.sv
module pte_access_guard
  import perm_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic              acc_super,
  input  logic [2:0]        pte_perm,
  input  logic              pte_modified,
  input  logic              nofault_en,
  input  logic [VA_W-1:0]   acc_vaddr,
  input  logic              fsr_rd,
  output logic [1:0]        err_code,
  output logic              grant_r,
  output logic              grant_w,
  output logic              grant_x,
  output logic [7:0]        fsr_q,
  output logic [VA_W-1:0]   far_q
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;
  logic [IDX_W-1:0]       acc_idx;
  rights_t                base_rights;
  logic [ERR_W-1:0]       raw_err;
  logic                   waive;
  logic                   rec_en;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  assign acc_idx = {acc_write, acc_fetch, acc_super};

  perm_rights rights_i (
    .perm       (pte_perm),
    .super_mode (acc_super),
    .rights     (base_rights)
  );

  perm_access_check check_i (
    .acc_idx (acc_idx),
    .perm    (pte_perm),
    .base    (base_rights),
    .err     (raw_err)
  );

  always_comb begin
    waive    = nofault_en & ~acc_super;
    err_code = waive ? ERR_NONE : raw_err;
    if (err_code == ERR_NONE) begin
      grant_r = base_rights.r;
      grant_w = base_rights.w & pte_modified;
      grant_x = base_rights.x;
    end else begin
      grant_r = 1'b0;
      grant_w = 1'b0;
      grant_x = 1'b0;
    end
    rec_en = acc_valid & (err_code != ERR_NONE);
  end

  perm_fault_log #(.VA_W(VA_W)) log_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rec_en  (rec_en),
    .rd_clr  (fsr_rd),
    .acc_idx (acc_idx),
    .err     (err_code),
    .vaddr   (acc_vaddr),
    .fsr_q   (fsr_q),
    .far_q   (far_q)
  );
endmodule

// File: rtl/pte_access_guard_chk.sv
module pte_access_guard_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            acc_super,
  input logic [2:0]      pte_perm,
  input logic            pte_modified,
  input logic            nofault_en,
  input logic [VA_W-1:0] acc_vaddr,
  input logic            fsr_rd,
  input logic [1:0]      err_code,
  input logic            grant_r,
  input logic            grant_w,
  input logic            grant_x,
  input logic [7:0]      fsr_q,
  input logic [VA_W-1:0] far_q
);
  logic faulting;
  assign faulting = acc_valid && (err_code != 2'd0);

  assert_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_super && pte_perm[2:1] == 2'b11 && !nofault_en) |-> err_code == 2'd3);

  assert_no_dirty_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_w |-> pte_modified);

  assert_denied_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'd0) |-> (!grant_r && !grant_w && !grant_x));

  assert_nofault_user_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nofault_en && !acc_super) |-> err_code == 2'd0);

  assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (faulting && !fsr_rd && fsr_q != 8'd0) |=> fsr_q[0]);

  assert_far_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    faulting |=> far_q == $past(acc_vaddr));

  assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_rd && !faulting) |=> fsr_q == 8'd0);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!faulting && !fsr_rd) |=> ($stable(fsr_q) && $stable(far_q)));
endmodule

bind pte_access_guard pte_access_guard_chk #(.VA_W(VA_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .acc_valid    (acc_valid),
  .acc_super    (acc_super),
  .pte_perm     (pte_perm),
  .pte_modified (pte_modified),
  .nofault_en   (nofault_en),
  .acc_vaddr    (acc_vaddr),
  .fsr_rd       (fsr_rd),
  .err_code     (err_code),
  .grant_r      (grant_r),
  .grant_w      (grant_w),
  .grant_x      (grant_x),
  .fsr_q        (fsr_q),
  .far_q        (far_q)
);

// File: tb/pte_access_guard_tb_top.sv
module pte_access_guard_tb_top;
  localparam int VA_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            acc_valid = 1'b0;
  logic            acc_write = 1'b0;
  logic            acc_fetch = 1'b0;
  logic            acc_super = 1'b0;
  logic [2:0]      pte_perm = 3'd0;
  logic            pte_modified = 1'b0;
  logic            nofault_en = 1'b0;
  logic [VA_W-1:0] acc_vaddr = '0;
  logic            fsr_rd = 1'b0;
  logic [1:0]      err_code;
  logic            grant_r;
  logic            grant_w;
  logic            grant_x;
  logic [7:0]      fsr_q;
  logic [VA_W-1:0] far_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pte_access_guard #(.VA_W(VA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_fetch(acc_fetch), .acc_super(acc_super), .pte_perm(pte_perm),
    .pte_modified(pte_modified), .nofault_en(nofault_en), .acc_vaddr(acc_vaddr),
    .fsr_rd(fsr_rd), .err_code(err_code), .grant_r(grant_r), .grant_w(grant_w),
    .grant_x(grant_x), .fsr_q(fsr_q), .far_q(far_q)
  );

  // expected error per row (index) with perm 7 in the top cell
  function automatic logic [1:0] exp_err(input logic [2:0] idx, input logic [2:0] perm);
    logic [15:0] row;
    case (idx)
      3'd0: row = {2'd3, 2'd3, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0};
      3'd1: row = {2'd0, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0};
      3'd2: row = {2'd3, 2'd3, 2'd2, 2'd0, 2'd0, 2'd0, 2'd2, 2'd2};
      3'd3: row = {2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd2, 2'd2};
      3'd4: row = {2'd3, 2'd3, 2'd2, 2'd2, 2'd0, 2'd2, 2'd0, 2'd2};
      3'd5: row = {2'd0, 2'd2, 2'd0, 2'd2, 2'd0, 2'd2, 2'd0, 2'd2};
      3'd6: row = {2'd3, 2'd3, 2'd2, 2'd2, 2'd0, 2'd2, 2'd2, 2'd2};
      default: row = {2'd0, 2'd2, 2'd2, 2'd2, 2'd0, 2'd2, 2'd2, 2'd2};
    endcase
    return row[perm*2 +: 2];
  endfunction

  function automatic logic [2:0] exp_base(input logic sup, input logic [2:0] perm);
    if (sup && perm == 3'd5) return 3'b110;
    if (sup && perm == 3'd6) return 3'b101;
    if (sup && perm == 3'd7) return 3'b111;
    case (perm)
      3'd0: return 3'b100;
      3'd1: return 3'b110;
      3'd2: return 3'b101;
      3'd3: return 3'b111;
      3'd4: return 3'b001;
      3'd5: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_acc(input logic w, input logic f, input logic s, input logic [2:0] p,
                         input logic m, input logic nf, input logic [VA_W-1:0] va,
                         input logic v, input logic rd);
    acc_write = w; acc_fetch = f; acc_super = s; pte_perm = p; pte_modified = m;
    nofault_en = nf; acc_vaddr = va; acc_valid = v; fsr_rd = rd;
  endtask

  // apply for one edge, then return strobes low at the following falling edge
  task automatic pulse();
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    fsr_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 reset fsr", 64'(fsr_q), 64'd0);
    check("R11 reset far", 64'(far_q), 64'd0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < 8; p++) begin
        for (int m = 0; m < 2; m++) begin
          logic [1:0] e;
          logic [2:0] g;
          set_acc(i[2], i[1], i[0], p[2:0], m[0], 1'b0, 32'h0, 1'b0, 1'b0);
          #1;
          e = exp_err(i[2:0], p[2:0]);
          g = (e != 2'd0) ? 3'b000 : exp_base(i[0], p[2:0]);
          if (m == 0) g[1] = 1'b0;
          check("R2 R3 err", 64'(err_code), 64'(e));
          check("R4 R5 R6 rights", 64'({grant_r, grant_w, grant_x}), 64'(g));
        end
      end
    end
  endtask

  task automatic t_first_fault();
    // user store to code 0: index 4, protection -> 0x80|2|2
    set_acc(1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 32'hDEAD_B000, 1'b1, 1'b0);
    pulse();
    check("R1 fsr fields", 64'(fsr_q), 64'h82);
    check("R9 far", 64'(far_q), 64'hDEAD_B000);
  endtask

  task automatic t_overflow();
    // supervisor load of code 4: index 1, protection; pending 0x82 -> 1|0x20|2
    set_acc(1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0, 32'h1234_5678, 1'b1, 1'b0);
    pulse();
    check("R8 overflow", 64'(fsr_q), 64'h23);
    check("R9 far second", 64'(far_q), 64'h1234_5678);
  endtask

  task automatic t_read_clear();
    set_acc(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1);
    pulse();
    check("R10 clear", 64'(fsr_q), 64'h0);
    check("R10 far kept", 64'(far_q), 64'h1234_5678);
    // pending user fetch fault then read plus new fault together
    set_acc(1'b0, 1'b1, 1'b0, 3'd6, 1'b1, 1'b0, 32'hA000_0004, 1'b1, 1'b0);
    pulse();
    check("R1 fetch priv", 64'(fsr_q), 64'h43);
    set_acc(1'b1, 1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 32'hB000_0008, 1'b1, 1'b1);
    pulse();
    check("R10 read with fault", 64'(fsr_q), 64'hE2);
    check("R9 far with read", 64'(far_q), 64'hB000_0008);
  endtask

  task automatic t_no_valid();
    set_acc(1'b1, 1'b0, 1'b0, 3'd7, 1'b0, 1'b0, 32'hFFFF_0000, 1'b0, 1'b0);
    #1;
    check("R11 err still shown", 64'(err_code), 64'd3);
    pulse();
    check("R11 fsr unchanged", 64'(fsr_q), 64'hE2);
    check("R11 far unchanged", 64'(far_q), 64'hB000_0008);
  endtask

  task automatic t_nofault();
    // user load of code 6 with no-fault: allowed, no rights, nothing logged
    set_acc(1'b0, 1'b0, 1'b0, 3'd6, 1'b1, 1'b1, 32'h5555_0000, 1'b1, 1'b0);
    #1;
    check("R7 err waived", 64'(err_code), 64'd0);
    check("R7 rights none", 64'({grant_r, grant_w, grant_x}), 64'b000);
    pulse();
    check("R7 no record fsr", 64'(fsr_q), 64'hE2);
    check("R7 no record far", 64'(far_q), 64'hB000_0008);
    // user store of code 0, modified clear: base R only
    set_acc(1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0);
    #1;
    check("R7 store waived", 64'(err_code), 64'd0);
    check("R7 R5 rights", 64'({grant_r, grant_w, grant_x}), 64'b100);
    // supervisor store of code 4 is not waived: index 5 -> 0xA0|2|2, after clear
    set_acc(1'b1, 1'b0, 1'b1, 3'd4, 1'b1, 1'b1, 32'h7777_1000, 1'b1, 1'b1);
    #1;
    check("R7 supervisor err", 64'(err_code), 64'd2);
    pulse();
    check("R7 supervisor logged", 64'(fsr_q), 64'hA2);
    check("R9 far supervisor", 64'(far_q), 64'h7777_1000);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sweep();
    @(negedge clk);
    t_first_fault();
    t_overflow();
    t_read_clear();
    t_no_valid();
    t_nofault();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule